// File: doc/BRIEF.md
# Interrupt Controller Command-Word Interface

This block is the programming front end of an eight-line interrupt controller. Software reaches it through one address bit and an 8-bit data bus, with separate write and read strobes. Writes to address 0 either open an initialization sequence or carry an operational command. Writes to address 1 either supply the next word of that sequence or load the mask. The block holds every configuration field and the rotating priority offset. It presents them as outputs to the request and priority logic next to it.

The block does not hold the request or in-service registers. It sees them through `isr_in` and `irr_in`, and changes them only by one-cycle clear pulses on `isr_clr` and `irr_clr`. The priority resolver tells it two things. The first is which line wins a poll (`win_valid`, `win_line`). The second is which in-service line ranks highest for a non-specific end of interrupt (`eoi_valid`, `eoi_line`).

Every output is registered. The effect of a strobe sampled at a rising edge appears just after that edge. Clear pulses last exactly one cycle.

Top module: `cwi_ctrl`

## Requirements
- R1: Reset, or a write to address 0 with bit 4 set, gives the following state in the next cycle:
  - mask, in-service read select, poll flag, special mask, rotate-on-auto-EOI, priority offset, vector base, special fully nested flag and auto-EOI are all 0;
  - after such a write, `need4` takes data bit 0, `single` takes data bit 1, `init_step` is 1, and `isr_clr` and `irr_clr` are all ones for one cycle.

  The same write restarts a sequence that is already in progress. `init_step` encodes idle=0 and steps 1, 2 and 3.
- R2: In step 1, an address-1 write stores data with its low three bits cleared as `vec_base`. The next step is 2 when `single` is 0; otherwise it is 3 when `need4` is 1 and 0 when it is not.
- R3: In step 2, an address-1 write changes no field. The next step is 3 when `need4` is 1 and 0 otherwise.
- R4: In step 3, an address-1 write sets `sfnm` from data bit 4 and `auto_eoi` from data bit 1, then returns to idle.
- R5: When idle, an address-1 write loads `mask` with the data.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command:
  - bit 2 sets `poll_pend`;
  - when bit 1 is set, bit 0 goes to `rd_isr_sel`;
  - when bit 6 is set, bit 5 goes to `spec_mask`.
- R7: An address-0 write with bits 4 and 3 clear is an operation selected by bits 7:5. Operation 0 clears `rot_aeoi`, operation 4 sets it, and operation 2 changes nothing.
- R8: Operations 1 and 5 pulse the `isr_clr` bit for `eoi_line` when `eoi_valid` is 1. Operation 5 also sets `prio_ofs` to `eoi_line`+1 (mod 8). When `eoi_valid` is 0, neither operation has any effect.
- R9: Operation 3 pulses the `isr_clr` bit named by data bits 2:0. Operation 7 does the same and also sets `prio_ofs` to that line+1 (mod 8).
- R10: Operation 6 sets `prio_ofs` to (data bits 2:0 + 1) mod 8.
- R11: Without a pending poll, a read returns one value in `rdata` in the next cycle:
  - `mask` at address 1;
  - `isr_in` at address 0 when `rd_isr_sel` is 1;
  - `irr_in` at address 0 when `rd_isr_sel` is 0.
- R12: With a poll pending, a read at either address clears `poll_pend`. If `win_valid` is 1, it returns `win_line` and pulses that line in both `isr_clr` and `irr_clr`. Otherwise it returns 7 and pulses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| isr_in | input | 8 | Current in-service register |
| irr_in | input | 8 | Current request register |
| eoi_valid | input | 1 | An in-service line is set |
| eoi_line | input | 3 | Highest-priority in-service line |
| win_valid | input | 1 | A request wins arbitration |
| win_line | input | 3 | Winning request line |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| rd_isr_sel | output | 1 | Address-0 read returns in-service when 1 |
| poll_pend | output | 1 | Poll requested for the next read |
| spec_mask | output | 1 | Special mask mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| sfnm | output | 1 | Special fully nested mode |
| single | output | 1 | Single controller, no cascade word |
| need4 | output | 1 | Fourth initialization word expected |
| prio_ofs | output | 3 | Line that currently has top priority |
| init_step | output | 2 | Initialization step, 0 when idle |
| isr_clr | output | 8 | One-cycle in-service clear pulses |
| irr_clr | output | 8 | One-cycle request clear pulses |

## Verification
The checker assumes a write and a read never share a cycle. On that assumption, a pending poll can only be removed by a read, and a read always clears it. The checker also assumes the resolver inputs are steady in the cycle a strobe is sampled. The bench drives one strobe at a time for exactly one cycle, and sets `eoi_*`, `win_*`, `isr_in` and `irr_in` before raising the strobe. It then holds them until the result has been compared.

// File: rtl/cwi_pkg.sv
package cwi_pkg;

    localparam int CWI_DW = 8;

    // bit positions in the command bytes
    localparam int B_INIT    = 4;
    localparam int B_MODE    = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;
    localparam int B_NEED4   = 0;
    localparam int B_SINGLE  = 1;
    localparam int B_SFNM    = 4;
    localparam int B_AEOI    = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } step_e;

    typedef enum logic [2:0] {
        OP_ROT_CLR   = 3'd0,
        OP_NSEOI     = 3'd1,
        OP_NOP       = 3'd2,
        OP_SEOI      = 3'd3,
        OP_ROT_SET   = 3'd4,
        OP_NSEOI_ROT = 3'd5,
        OP_SET_PRI   = 3'd6,
        OP_SEOI_ROT  = 3'd7
    } op_e;

    typedef struct packed {
        logic [CWI_DW-1:0] base;
        logic              sfnm;
        logic              aeoi;
        logic              single;
        logic              need4;
    } init_cfg_t;

    typedef struct packed {
        logic [CWI_DW-1:0] clr_vec;
        logic              ofs_valid;
        logic [2:0]        ofs_val;
        logic              rot_valid;
        logic              rot_val;
    } op_act_t;

    function automatic logic [CWI_DW-1:0] line_bit(input logic [2:0] line);
        logic [CWI_DW-1:0] v;
        v = '0;
        v[line] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cwi_init_seq.sv
module cwi_init_seq
    import cwi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_wr,
    input  logic              data_wr,
    input  logic [CWI_DW-1:0] wdata,
    output step_e             step,
    output init_cfg_t         cfg,
    output logic              mask_wr
);

    localparam logic [CWI_DW-1:0] BASE_KEEP = ~CWI_DW'((1 << LW) - 1);

    assign mask_wr = data_wr && !init_wr && (step == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            cfg  <= '0;
        end else if (init_wr) begin
            cfg        <= '0;
            cfg.need4  <= wdata[B_NEED4];
            cfg.single <= wdata[B_SINGLE];
            step       <= ST_BASE;
        end else if (data_wr) begin
            case (step)
                ST_BASE: begin
                    cfg.base <= wdata & BASE_KEEP;
                    if (!cfg.single)
                        step <= ST_CASC;
                    else
                        step <= cfg.need4 ? ST_MODE : ST_IDLE;
                end
                ST_CASC: begin
                    step <= cfg.need4 ? ST_MODE : ST_IDLE;
                end
                ST_MODE: begin
                    cfg.sfnm <= wdata[B_SFNM];
                    cfg.aeoi <= wdata[B_AEOI];
                    step     <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cwi_cmd_dec.sv
module cwi_cmd_dec
    import cwi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              op_wr,
    input  logic [CWI_DW-1:0] wdata,
    input  logic              eoi_valid,
    input  logic [LW-1:0]     eoi_line,
    output op_act_t           act
);

    op_e           op;
    logic [LW-1:0] named;

    assign op    = op_e'(wdata[CWI_DW-1:CWI_DW-3]);
    assign named = wdata[LW-1:0];

    always_comb begin
        act = '0;
        if (op_wr) begin
            case (op)
                OP_ROT_CLR: begin
                    act.rot_valid = 1'b1;
                    act.rot_val   = 1'b0;
                end
                OP_ROT_SET: begin
                    act.rot_valid = 1'b1;
                    act.rot_val   = 1'b1;
                end
                OP_NSEOI, OP_NSEOI_ROT: begin
                    if (eoi_valid) begin
                        act.clr_vec = line_bit(eoi_line);
                        if (op == OP_NSEOI_ROT) begin
                            act.ofs_valid = 1'b1;
                            act.ofs_val   = eoi_line + 1'b1;
                        end
                    end
                end
                OP_SEOI, OP_SEOI_ROT: begin
                    act.clr_vec = line_bit(named);
                    if (op == OP_SEOI_ROT) begin
                        act.ofs_valid = 1'b1;
                        act.ofs_val   = named + 1'b1;
                    end
                end
                OP_SET_PRI: begin
                    act.ofs_valid = 1'b1;
                    act.ofs_val   = named + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cwi_rd_path.sv
module cwi_rd_path
    import cwi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              addr,
    input  logic              poll_pend,
    input  logic              rd_isr_sel,
    input  logic [CWI_DW-1:0] mask,
    input  logic [CWI_DW-1:0] isr_in,
    input  logic [CWI_DW-1:0] irr_in,
    input  logic              win_valid,
    input  logic [LW-1:0]     win_line,
    output logic              poll_take,
    output logic [CWI_DW-1:0] poll_vec,
    output logic [CWI_DW-1:0] rdata
);

    localparam logic [CWI_DW-1:0] NO_WIN = CWI_DW'(NLINES - 1);

    logic [CWI_DW-1:0] rd_next;

    assign poll_take = rd_en && poll_pend;
    assign poll_vec  = (poll_take && win_valid) ? line_bit(win_line) : '0;

    always_comb begin
        if (poll_pend)
            rd_next = win_valid ? CWI_DW'(win_line) : NO_WIN;
        else if (addr)
            rd_next = mask;
        else
            rd_next = rd_isr_sel ? isr_in : irr_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

endmodule

// File: rtl/cwi_ctrl.sv
module cwi_ctrl
    import cwi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr,
    input  logic [CWI_DW-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CWI_DW-1:0] isr_in,
    input  logic [CWI_DW-1:0] irr_in,
    input  logic              eoi_valid,
    input  logic [LW-1:0]     eoi_line,
    input  logic              win_valid,
    input  logic [LW-1:0]     win_line,
    output logic [CWI_DW-1:0] rdata,
    output logic [CWI_DW-1:0] mask,
    output logic [CWI_DW-1:0] vec_base,
    output logic              rd_isr_sel,
    output logic              poll_pend,
    output logic              spec_mask,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              sfnm,
    output logic              single,
    output logic              need4,
    output logic [LW-1:0]     prio_ofs,
    output logic [1:0]        init_step,
    output logic [CWI_DW-1:0] isr_clr,
    output logic [CWI_DW-1:0] irr_clr
);

    logic              wr_cmd, init_wr, mode_wr, op_wr, data_wr, mask_wr;
    logic              poll_take;
    logic [CWI_DW-1:0] poll_vec;
    step_e             step;
    init_cfg_t         cfg;
    op_act_t           act;

    assign wr_cmd  = wr_en && !addr;
    assign init_wr = wr_cmd && wdata[B_INIT];
    assign mode_wr = wr_cmd && !wdata[B_INIT] && wdata[B_MODE];
    assign op_wr   = wr_cmd && !wdata[B_INIT] && !wdata[B_MODE];
    assign data_wr = wr_en && addr;

    cwi_init_seq #(.NLINES(NLINES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .init_wr (init_wr),
        .data_wr (data_wr),
        .wdata   (wdata),
        .step    (step),
        .cfg     (cfg),
        .mask_wr (mask_wr)
    );

    cwi_cmd_dec #(.NLINES(NLINES)) u_dec (
        .op_wr     (op_wr),
        .wdata     (wdata),
        .eoi_valid (eoi_valid),
        .eoi_line  (eoi_line),
        .act       (act)
    );

    cwi_rd_path #(.NLINES(NLINES)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .addr       (addr),
        .poll_pend  (poll_pend),
        .rd_isr_sel (rd_isr_sel),
        .mask       (mask),
        .isr_in     (isr_in),
        .irr_in     (irr_in),
        .win_valid  (win_valid),
        .win_line   (win_line),
        .poll_take  (poll_take),
        .poll_vec   (poll_vec),
        .rdata      (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst || init_wr) begin
            mask       <= '0;
            rd_isr_sel <= 1'b0;
            poll_pend  <= 1'b0;
            spec_mask  <= 1'b0;
            rot_aeoi   <= 1'b0;
            prio_ofs   <= '0;
        end else begin
            if (mask_wr)
                mask <= wdata;
            if (poll_take)
                poll_pend <= 1'b0;
            if (mode_wr) begin
                if (wdata[B_POLL])
                    poll_pend <= 1'b1;
                if (wdata[B_RSEL_EN])
                    rd_isr_sel <= wdata[B_RSEL];
                if (wdata[B_SMM_EN])
                    spec_mask <= wdata[B_SMM];
            end
            if (act.rot_valid)
                rot_aeoi <= act.rot_val;
            if (act.ofs_valid)
                prio_ofs <= act.ofs_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_clr <= '0;
            irr_clr <= '0;
        end else if (init_wr) begin
            isr_clr <= '1;
            irr_clr <= '1;
        end else begin
            isr_clr <= act.clr_vec | poll_vec;
            irr_clr <= poll_vec;
        end
    end

    assign vec_base  = cfg.base;
    assign auto_eoi  = cfg.aeoi;
    assign sfnm      = cfg.sfnm;
    assign single    = cfg.single;
    assign need4     = cfg.need4;
    assign init_step = step;

endmodule

// File: rtl/cwi_ctrl_chk.sv
module cwi_ctrl_chk #(
    parameter int NLINES = 8,
    localparam int LW = $clog2(NLINES),
    localparam int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          addr,
    input logic [DW-1:0] wdata,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] mask,
    input logic [DW-1:0] vec_base,
    input logic          poll_pend,
    input logic          single,
    input logic [LW-1:0] prio_ofs,
    input logic [1:0]    init_step,
    input logic [DW-1:0] isr_clr,
    input logic [DW-1:0] irr_clr
);

    localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << LW) - 1);

    // R1: initialization word opens step 1 and clears both registers
    a_r1_init_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4]) |=> (init_step == 2'd1 && isr_clr == '1 && irr_clr == '1));

    // R2: base word keeps only the upper bits
    a_r2_base_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && init_step == 2'd1) |=> (vec_base == ($past(wdata) & BASE_KEEP)));

    // R3: the cascade step is never visited in single mode
    a_r3_no_casc_single: assert property (@(posedge clk) disable iff (rst)
        (init_step == 2'd2) |-> !single);

    // R5: idle data write loads the mask
    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && init_step == 2'd0) |=> (mask == $past(wdata)));

    // R10: explicit priority set
    a_r10_set_pri: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[7:3] == 5'b11000) |=> (prio_ofs == LW'($past(wdata[LW-1:0]) + 1'b1)));

    // R12: a read consumes a pending poll
    a_r12_poll_consumed: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && poll_pend) |=> !poll_pend);

    // R12: without any strobe the poll flag holds
    a_r12_poll_holds: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |=> $stable(poll_pend));

    // R12: poll clears touch at most one request line
    a_r12_irr_onehot: assert property (@(posedge clk) disable iff (rst)
        (irr_clr != '1) |-> $onehot0(irr_clr));

endmodule

bind cwi_ctrl cwi_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .mask      (mask),
    .vec_base  (vec_base),
    .poll_pend (poll_pend),
    .single    (single),
    .prio_ofs  (prio_ofs),
    .init_step (init_step),
    .isr_clr   (isr_clr),
    .irr_clr   (irr_clr)
);

// File: tb/cwi_ctrl_bench.sv
`timescale 1ns/1ps
module cwi_ctrl_bench;

    localparam int SEL_RDATA = 0, SEL_MASK = 1, SEL_STEP = 2, SEL_BASE = 3,
                   SEL_ISRC = 4, SEL_IRRC = 5, SEL_POLL = 6, SEL_RSEL = 7,
                   SEL_SMM = 8, SEL_ROT = 9, SEL_OFS = 10, SEL_SFNM = 11,
                   SEL_AEOI = 12, SEL_SINGLE = 13, SEL_NEED4 = 14;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] isr_in = '0;
    logic [7:0] irr_in = '0;
    logic       eoi_valid = 1'b0;
    logic [2:0] eoi_line = '0;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, mask, vec_base, isr_clr, irr_clr;
    logic       rd_isr_sel, poll_pend, spec_mask, auto_eoi, rot_aeoi, sfnm, single, need4;
    logic [2:0] prio_ofs;
    logic [1:0] init_step;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    item_t sb[$];
    event  ev_chk;

    always #2.5 clk = ~clk;

    cwi_ctrl u_cwi_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .isr_in(isr_in), .irr_in(irr_in), .eoi_valid(eoi_valid), .eoi_line(eoi_line),
        .win_valid(win_valid), .win_line(win_line), .rdata(rdata), .mask(mask),
        .vec_base(vec_base), .rd_isr_sel(rd_isr_sel), .poll_pend(poll_pend),
        .spec_mask(spec_mask), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .sfnm(sfnm),
        .single(single), .need4(need4), .prio_ofs(prio_ofs), .init_step(init_step),
        .isr_clr(isr_clr), .irr_clr(irr_clr)
    );

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            SEL_RDATA:  return rdata;
            SEL_MASK:   return mask;
            SEL_STEP:   return {6'd0, init_step};
            SEL_BASE:   return vec_base;
            SEL_ISRC:   return isr_clr;
            SEL_IRRC:   return irr_clr;
            SEL_POLL:   return {7'd0, poll_pend};
            SEL_RSEL:   return {7'd0, rd_isr_sel};
            SEL_SMM:    return {7'd0, spec_mask};
            SEL_ROT:    return {7'd0, rot_aeoi};
            SEL_OFS:    return {5'd0, prio_ofs};
            SEL_SFNM:   return {7'd0, sfnm};
            SEL_AEOI:   return {7'd0, auto_eoi};
            SEL_SINGLE: return {7'd0, single};
            SEL_NEED4:  return {7'd0, need4};
            default:    return 8'hxx;
        endcase
    endfunction

    // monitor: pops the scoreboard and compares against the ports
    initial begin
        forever begin
            @(ev_chk);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = sb.pop_front();
                got = observe(it.sel);
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: sel %0d got %02h expected %02h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input int sel, input logic [7:0] v, input string req);
        item_t it;
        it.sel = sel;
        it.exp = v;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic compare_now();
        -> ev_chk;
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_v(SEL_STEP, 8'h00, "R1 reset");
        expect_v(SEL_MASK, 8'h00, "R1 reset");
        expect_v(SEL_POLL, 8'h00, "R1 reset");
        compare_now();

        // R1: cascaded, fourth word
        wr(1'b0, 8'h11);
        expect_v(SEL_STEP, 8'h01, "R1 step");
        expect_v(SEL_NEED4, 8'h01, "R1 need4");
        expect_v(SEL_SINGLE, 8'h00, "R1 single");
        expect_v(SEL_ISRC, 8'hFF, "R1 isr clear");
        expect_v(SEL_IRRC, 8'hFF, "R1 irr clear");
        compare_now();
        // R2
        wr(1'b1, 8'h4D);
        expect_v(SEL_BASE, 8'h48, "R2 base");
        expect_v(SEL_STEP, 8'h02, "R2 next cascade");
        compare_now();
        // R3: data ignored
        wr(1'b1, 8'hFF);
        expect_v(SEL_STEP, 8'h03, "R3 next");
        expect_v(SEL_BASE, 8'h48, "R3 base kept");
        expect_v(SEL_MASK, 8'h00, "R3 mask kept");
        compare_now();
        // R4
        wr(1'b1, 8'h12);
        expect_v(SEL_SFNM, 8'h01, "R4 sfnm");
        expect_v(SEL_AEOI, 8'h01, "R4 aeoi");
        expect_v(SEL_STEP, 8'h00, "R4 idle");
        compare_now();
        // R5
        wr(1'b1, 8'hA5);
        expect_v(SEL_MASK, 8'hA5, "R5 mask");
        compare_now();

        // R11 reads
        rd(1'b1);
        expect_v(SEL_RDATA, 8'hA5, "R11 mask read");
        compare_now();
        irr_in = 8'h3C;
        isr_in = 8'h81;
        rd(1'b0);
        expect_v(SEL_RDATA, 8'h3C, "R11 request read");
        compare_now();
        // R6 read select
        wr(1'b0, 8'h0B);
        expect_v(SEL_RSEL, 8'h01, "R6 read select");
        compare_now();
        rd(1'b0);
        expect_v(SEL_RDATA, 8'h81, "R11 in-service read");
        compare_now();
        wr(1'b0, 8'h68);
        expect_v(SEL_SMM, 8'h01, "R6 special mask set");
        expect_v(SEL_RSEL, 8'h01, "R6 select kept");
        compare_now();
        wr(1'b0, 8'h48);
        expect_v(SEL_SMM, 8'h00, "R6 special mask clear");
        compare_now();

        // R7
        wr(1'b0, 8'h80);
        expect_v(SEL_ROT, 8'h01, "R7 rotate set");
        compare_now();
        wr(1'b0, 8'h00);
        expect_v(SEL_ROT, 8'h00, "R7 rotate clear");
        compare_now();
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h40);
        expect_v(SEL_ROT, 8'h01, "R7 nop rotate");
        expect_v(SEL_OFS, 8'h00, "R7 nop offset");
        expect_v(SEL_ISRC, 8'h00, "R7 nop clear");
        compare_now();

        // R8
        eoi_valid = 1'b1;
        eoi_line  = 3'd5;
        wr(1'b0, 8'h20);
        expect_v(SEL_ISRC, 8'h20, "R8 nonspecific clear");
        expect_v(SEL_OFS, 8'h00, "R8 no rotate");
        compare_now();
        eoi_line = 3'd3;
        wr(1'b0, 8'hA0);
        expect_v(SEL_ISRC, 8'h08, "R8 rotate clear");
        expect_v(SEL_OFS, 8'h04, "R8 rotate offset");
        compare_now();
        eoi_valid = 1'b0;
        wr(1'b0, 8'h20);
        expect_v(SEL_ISRC, 8'h00, "R8 empty no clear");
        compare_now();
        eoi_line = 3'd6;
        wr(1'b0, 8'hA0);
        expect_v(SEL_ISRC, 8'h00, "R8 empty rotate no clear");
        expect_v(SEL_OFS, 8'h04, "R8 empty offset kept");
        compare_now();

        // R9
        wr(1'b0, 8'h66);
        expect_v(SEL_ISRC, 8'h40, "R9 specific clear");
        expect_v(SEL_OFS, 8'h04, "R9 offset kept");
        compare_now();
        wr(1'b0, 8'hE2);
        expect_v(SEL_ISRC, 8'h04, "R9 specific rotate clear");
        expect_v(SEL_OFS, 8'h03, "R9 specific rotate offset");
        compare_now();

        // R10
        wr(1'b0, 8'hC7);
        expect_v(SEL_OFS, 8'h00, "R10 wrap");
        compare_now();
        wr(1'b0, 8'hC3);
        expect_v(SEL_OFS, 8'h04, "R10 offset");
        compare_now();

        // R12 poll with a winner
        wr(1'b0, 8'h0C);
        expect_v(SEL_POLL, 8'h01, "R6 poll");
        compare_now();
        win_valid = 1'b1;
        win_line  = 3'd6;
        rd(1'b1);
        expect_v(SEL_RDATA, 8'h06, "R12 poll line");
        expect_v(SEL_ISRC, 8'h40, "R12 poll isr clear");
        expect_v(SEL_IRRC, 8'h40, "R12 poll irr clear");
        expect_v(SEL_POLL, 8'h00, "R12 poll consumed");
        compare_now();
        rd(1'b1);
        expect_v(SEL_RDATA, 8'hA5, "R12 normal read after poll");
        expect_v(SEL_IRRC, 8'h00, "R12 no clear after poll");
        compare_now();
        // R12 no winner
        wr(1'b0, 8'h0C);
        win_valid = 1'b0;
        rd(1'b0);
        expect_v(SEL_RDATA, 8'h07, "R12 no winner");
        expect_v(SEL_ISRC, 8'h00, "R12 no winner clear");
        expect_v(SEL_POLL, 8'h00, "R12 consumed");
        compare_now();

        // R1 clears configured state; R2 single without fourth word
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h12);
        expect_v(SEL_MASK, 8'h00, "R1 mask cleared");
        expect_v(SEL_ROT, 8'h00, "R1 rotate cleared");
        expect_v(SEL_OFS, 8'h00, "R1 offset cleared");
        expect_v(SEL_SFNM, 8'h00, "R1 sfnm cleared");
        expect_v(SEL_AEOI, 8'h00, "R1 aeoi cleared");
        expect_v(SEL_RSEL, 8'h00, "R1 select cleared");
        expect_v(SEL_BASE, 8'h00, "R1 base cleared");
        expect_v(SEL_SINGLE, 8'h01, "R1 single");
        expect_v(SEL_NEED4, 8'h00, "R1 need4");
        compare_now();
        wr(1'b1, 8'hF3);
        expect_v(SEL_BASE, 8'hF0, "R2 base single");
        expect_v(SEL_STEP, 8'h00, "R2 single no fourth");
        compare_now();

        // R2 single with fourth word; R4 fields
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h08);
        expect_v(SEL_STEP, 8'h03, "R2 single fourth");
        compare_now();
        wr(1'b1, 8'h02);
        expect_v(SEL_AEOI, 8'h01, "R4 aeoi only");
        expect_v(SEL_SFNM, 8'h00, "R4 sfnm clear");
        expect_v(SEL_STEP, 8'h00, "R4 idle");
        compare_now();

        // R3 cascaded without fourth word
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h20);
        expect_v(SEL_STEP, 8'h02, "R3 cascade step");
        compare_now();
        wr(1'b1, 8'h55);
        expect_v(SEL_STEP, 8'h00, "R3 end without fourth");
        expect_v(SEL_MASK, 8'h00, "R3 mask untouched");
        compare_now();

        // R1 restart mid-sequence
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h13);
        expect_v(SEL_STEP, 8'h01, "R1 restart");
        expect_v(SEL_SINGLE, 8'h01, "R1 restart single");
        compare_now();

        done = 1;
        finish_run();
    end

endmodule